// File: doc/BRIEF.md
# 40-bit Saturating Accumulator Unit

This block is the accumulate stage of a multiply/accumulate datapath. It holds a 40-bit accumulator and, on each accepted command, either clears it, preloads it with a 32-bit value built from two 16-bit words, or adds or subtracts a 32-bit signed operand. The operand comes from one of two places. It can be a product, optionally scaled left by one bit. It can also be the concatenation of the two 16-bit words. The operand is sign-extended to 40 bits before the arithmetic. The eight bits above the 32-bit range act as guard bits, so a long run of accumulations can go past the 32-bit range and come back without losing information.

After an add or subtract, the unit can add a rounding constant at bit 15. It can also clamp the result to the 32-bit signed range. Both happen in the same cycle, and rounding comes first. A sticky flag records every clamp event and every wrap of the full 40-bit width, and it stays set until it is cleared explicitly.

Top module: `sacc_top`

## Requirements
- R1: A synchronous active-high `rst` sets `acc_o` to 0 and `ovf_o` to 0 on the next rising edge.
- R2: While `op_valid_i` is 0, `acc_o` keeps its value whatever the other command inputs carry.
- R3: With `op_valid_i`=1 and `op_i`=2'b00 (clear), `acc_o` becomes 0 on the next edge and `ovf_o` is not changed by the command.
- R4: With `op_i`=2'b01 (load), `acc_o` becomes the sign-extension of {`word_hi_i`,`word_lo_i`}, with `word_hi_i` in bits 31:16. The load ignores `src_sel_i`, `round_i` and `sat_en_i` and does not change `ovf_o`.
- R5: With `op_i`=2'b10 (add) or 2'b11 (subtract), and with rounding and saturation off, `acc_o` becomes `acc_o` plus or minus the sign-extended operand, modulo 2^40.
- R6: The add/subtract operand is `prod_i` when `src_sel_i`=0. When `prod_shl_i`=1 as well, the product is shifted left by one and its bit 31 is dropped. When `src_sel_i`=1, the operand is {`word_hi_i`,`word_lo_i`}.
- R7: When `round_i`=1 on an add or subtract, 0x8000 is also added to the result in the same cycle.
- R8: When `sat_en_i`=1 on an add or subtract, the exact result is taken after rounding. If it lies outside the 32-bit signed range, `acc_o` becomes 0x00_7FFF_FFFF when that result is positive and 0xFF_8000_0000 when it is negative. This holds for both add and subtract.
- R9: With `sat_en_i`=0, a result that lies outside the 32-bit range but inside the 40-bit range is kept exactly and does not set `ovf_o`.
- R10: `ovf_o` is set on the edge after a clamp (R8) or after an add/subtract whose exact result leaves the 40-bit signed range. It then stays set. A set event in the same cycle as `ovf_clr_i` wins.
- R11: `ovf_clr_i`=1 with no set event clears `ovf_o` on the next edge, whether or not a command is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Command valid |
| op_i | input | 2 | 00 clear, 01 load, 10 add, 11 subtract |
| src_sel_i | input | 1 | Operand source: 0 product, 1 word pair |
| prod_i | input | 32 | Signed product operand |
| prod_shl_i | input | 1 | Shift product left by one |
| word_hi_i | input | 16 | Upper word of the concatenated operand |
| word_lo_i | input | 16 | Lower word of the concatenated operand |
| round_i | input | 1 | Add rounding constant on add/subtract |
| sat_en_i | input | 1 | Clamp add/subtract results to 32 bits |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| acc_o | output | 40 | Registered accumulator |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Directed cases first show that guard bits let an unclamped result reach 0x00_8000_0000 with no flag, while the same step with clamping enabled stops at 0x00_7FFF_FFFF. A subtract of a negative operand shows that the clamp direction follows the sign of the exact result and not the operation. A run of 256 large additions drives the accumulator through its 40-bit wrap, which checks that wrap detection is separate from the 32-bit clamp. Round-then-clamp at the 0x7FFF_8000 boundary fixes the order of the two steps. Seeded random commands then mix near-extreme and small operands with random round, clamp and clear requests. This exercises the flag priority and every operation order against a reference model written in wide integer arithmetic.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  typedef enum logic [1:0] {
    SACC_CLR  = 2'b00,
    SACC_LOAD = 2'b01,
    SACC_ADD  = 2'b10,
    SACC_SUB  = 2'b11
  } sacc_op_e;

endpackage

// File: rtl/sacc_operand.sv
module sacc_operand #(
  parameter int OPD_W = 32
) (
  input  logic [OPD_W-1:0]   prod_i,
  input  logic               prod_shl_i,
  input  logic [OPD_W/2-1:0] word_hi_i,
  input  logic [OPD_W/2-1:0] word_lo_i,
  input  logic               src_sel_i,
  output logic [OPD_W-1:0]   opnd_o,
  output logic [OPD_W-1:0]   cat_o
);

  logic [OPD_W-1:0] prod_sc;

  always_comb begin
    cat_o   = {word_hi_i, word_lo_i};
    prod_sc = prod_shl_i ? {prod_i[OPD_W-2:0], 1'b0} : prod_i;
    opnd_o  = src_sel_i ? cat_o : prod_sc;
  end

endmodule

// File: rtl/sacc_arith.sv
module sacc_arith #(
  parameter int ACC_W   = 40,
  parameter int OPD_W   = 32,
  parameter int RND_BIT = 15
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [OPD_W-1:0] opnd_i,
  input  logic             sub_i,
  input  logic             rnd_i,
  output logic [ACC_W+1:0] exact_o
);

  localparam int EXT_W = ACC_W + 2;

  logic [EXT_W-1:0] a_x;
  logic [EXT_W-1:0] b_x;
  logic [EXT_W-1:0] b_eff;
  logic [EXT_W-1:0] cin_x;
  logic [EXT_W-1:0] rnd_x;

  always_comb begin
    a_x          = {{2{acc_i[ACC_W-1]}}, acc_i};
    b_x          = {{(EXT_W-OPD_W){opnd_i[OPD_W-1]}}, opnd_i};
    b_eff        = sub_i ? ~b_x : b_x;
    cin_x        = '0;
    cin_x[0]     = sub_i;
    rnd_x        = '0;
    rnd_x[RND_BIT] = rnd_i;
    exact_o      = a_x + b_eff + cin_x + rnd_x;
  end

endmodule

// File: rtl/sacc_limit.sv
module sacc_limit #(
  parameter int ACC_W = 40,
  parameter int OPD_W = 32
) (
  input  logic [ACC_W+1:0] exact_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] result_o,
  output logic             sat_hit_o,
  output logic             wrap_hit_o
);

  localparam int EXT_W   = ACC_W + 2;
  localparam int GUARD_W = ACC_W - OPD_W;
  localparam logic [ACC_W-1:0] POS_LIM = {{(GUARD_W+1){1'b0}}, {(OPD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{(GUARD_W+1){1'b1}}, {(OPD_W-1){1'b0}}};

  logic [EXT_W-OPD_W:0] top32;
  logic [2:0]           top40;
  logic                 out32;
  logic                 out40;

  always_comb begin
    top32      = exact_i[EXT_W-1:OPD_W-1];
    top40      = exact_i[EXT_W-1:ACC_W-1];
    out32      = !((&top32) || !(|top32));
    out40      = !((&top40) || !(|top40));
    sat_hit_o  = sat_en_i && out32;
    wrap_hit_o = !sat_en_i && out40;
    if (sat_hit_o) result_o = exact_i[EXT_W-1] ? NEG_LIM : POS_LIM;
    else           result_o = exact_i[ACC_W-1:0];
  end

endmodule

// File: rtl/sacc_top.sv
module sacc_top
  import sacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int OPD_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid_i,
  input  logic [1:0]         op_i,
  input  logic               src_sel_i,
  input  logic [OPD_W-1:0]   prod_i,
  input  logic               prod_shl_i,
  input  logic [OPD_W/2-1:0] word_hi_i,
  input  logic [OPD_W/2-1:0] word_lo_i,
  input  logic               round_i,
  input  logic               sat_en_i,
  input  logic               ovf_clr_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               ovf_o
);

  localparam int HALF_W  = OPD_W / 2;
  localparam int GUARD_W = ACC_W - OPD_W;
  localparam int RND_BIT = HALF_W - 1;

  sacc_op_e         op;
  logic [OPD_W-1:0] opnd;
  logic [OPD_W-1:0] cat;
  logic [ACC_W+1:0] exact;
  logic [ACC_W-1:0] limited;
  logic             sat_hit;
  logic             wrap_hit;
  logic             arith_op;
  logic             ovf_evt;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             ovf_q, ovf_d;

  assign op = sacc_op_e'(op_i);

  sacc_operand #(.OPD_W(OPD_W)) i_operand (
    .prod_i    (prod_i),
    .prod_shl_i(prod_shl_i),
    .word_hi_i (word_hi_i),
    .word_lo_i (word_lo_i),
    .src_sel_i (src_sel_i),
    .opnd_o    (opnd),
    .cat_o     (cat)
  );

  sacc_arith #(.ACC_W(ACC_W), .OPD_W(OPD_W), .RND_BIT(RND_BIT)) i_arith (
    .acc_i  (acc_q),
    .opnd_i (opnd),
    .sub_i  (op == SACC_SUB),
    .rnd_i  (round_i),
    .exact_o(exact)
  );

  sacc_limit #(.ACC_W(ACC_W), .OPD_W(OPD_W)) i_limit (
    .exact_i   (exact),
    .sat_en_i  (sat_en_i),
    .result_o  (limited),
    .sat_hit_o (sat_hit),
    .wrap_hit_o(wrap_hit)
  );

  always_comb begin
    arith_op = op_valid_i && (op == SACC_ADD || op == SACC_SUB);
    ovf_evt  = arith_op && (sat_hit || wrap_hit);
    acc_d    = acc_q;
    if (op_valid_i) begin
      case (op)
        SACC_CLR:  acc_d = '0;
        SACC_LOAD: acc_d = {{GUARD_W{cat[OPD_W-1]}}, cat};
        default:   acc_d = limited;
      endcase
    end
    if (ovf_evt)        ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
    else                ovf_d = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !ovf_q));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> $stable(acc_q));

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i == 2'b00) |=> (acc_q == '0));

  a_r4_load_words: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i == 2'b01) |=>
      (acc_q == {{GUARD_W{$past(word_hi_i[HALF_W-1])}}, $past(word_hi_i), $past(word_lo_i)}));

  a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i[1] && sat_en_i) |=>
      ((&acc_q[ACC_W-1:OPD_W-1]) || !(|acc_q[ACC_W-1:OPD_W-1])));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_q);

  a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr_i && !ovf_evt) |=> !ovf_q);

endmodule

// File: tb/test_sacc_top.sv
module test_sacc_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid_i;
  logic [1:0]  op_i;
  logic        src_sel_i;
  logic [31:0] prod_i;
  logic        prod_shl_i;
  logic [15:0] word_hi_i;
  logic [15:0] word_lo_i;
  logic        round_i;
  logic        sat_en_i;
  logic        ovf_clr_i;
  logic [39:0] acc_o;
  logic        ovf_o;

  int n_cmp  = 0;
  int n_fail = 0;

  logic [39:0] m_acc;
  logic        m_ovf;

  always #(CLK_P/2) clk = ~clk;

  sacc_top i_sacc_top (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .src_sel_i(src_sel_i), .prod_i(prod_i), .prod_shl_i(prod_shl_i),
    .word_hi_i(word_hi_i), .word_lo_i(word_lo_i), .round_i(round_i),
    .sat_en_i(sat_en_i), .ovf_clr_i(ovf_clr_i), .acc_o(acc_o), .ovf_o(ovf_o)
  );

  function automatic logic [31:0] ref_opnd(logic s, logic [31:0] p, logic sh,
                                           logic [15:0] h, logic [15:0] l);
    if (s) return {h, l};
    if (sh) return p << 1;
    return p;
  endfunction

  function automatic logic [40:0] ref_step(logic [39:0] a, logic f, logic v,
      logic [1:0] op, logic [31:0] b, logic [31:0] cat, logic rnd, logic sat,
      logic clr);
    longint e, as, bs;
    logic [63:0] ev;
    logic [39:0] r;
    logic evt;
    r = a; evt = 1'b0;
    if (v) begin
      if (op == 2'b00) r = '0;
      else if (op == 2'b01) r = {{8{cat[31]}}, cat};
      else begin
        as = longint'($signed(a));
        bs = longint'($signed(b));
        e  = (op == 2'b11) ? as - bs : as + bs;
        if (rnd) e = e + 32768;
        if (sat && (e > 64'sd2147483647 || e < -64'sd2147483648)) begin
          r = (e > 0) ? 40'h00_7FFF_FFFF : 40'hFF_8000_0000;
          evt = 1'b1;
        end else begin
          ev = 64'(e);
          r  = ev[39:0];
          if (e > 64'sd549755813887 || e < -64'sd549755813888) evt = 1'b1;
        end
      end
    end
    return {evt ? 1'b1 : (clr ? 1'b0 : f), r};
  endfunction

  task automatic check(string tag, logic [39:0] a_act, logic f_act,
                       logic [39:0] a_exp, logic f_exp);
    n_cmp++;
    if (a_act !== a_exp || f_act !== f_exp) begin
      n_fail++;
      $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b",
               tag, a_act, f_act, a_exp, f_exp);
    end
  endtask

  task automatic cyc(string tag, logic v, logic [1:0] op, logic s, logic [31:0] p,
                     logic sh, logic [15:0] h, logic [15:0] l, logic rnd,
                     logic sat, logic clr);
    logic [40:0] nx;
    @(negedge clk);
    op_valid_i = v; op_i = op; src_sel_i = s; prod_i = p; prod_shl_i = sh;
    word_hi_i = h; word_lo_i = l; round_i = rnd; sat_en_i = sat; ovf_clr_i = clr;
    nx = ref_step(m_acc, m_ovf, v, op, ref_opnd(s, p, sh, h, l), {h, l}, rnd, sat, clr);
    m_acc = nx[39:0]; m_ovf = nx[40];
    @(posedge clk); #1;
    check(tag, acc_o, ovf_o, m_acc, m_ovf);
  endtask

  task automatic lit(string tag, logic [39:0] a_exp, logic f_exp);
    check(tag, acc_o, ovf_o, a_exp, f_exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid_i = 1'b1; op_i = 2'b10; ovf_clr_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0; op_valid_i = 1'b0;
    m_acc = '0; m_ovf = 1'b0;
    check("R1", acc_o, ovf_o, 40'h0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: acc=%h ovf=%b expected run to finish", acc_o, ovf_o);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_C3E1));
    rst = 1'b1; op_valid_i = 0; op_i = 0; src_sel_i = 0; prod_i = 0;
    prod_shl_i = 0; word_hi_i = 0; word_lo_i = 0; round_i = 0; sat_en_i = 0;
    ovf_clr_i = 0;
    repeat (3) @(posedge clk);
    do_reset();

    // R4 loads, positive and negative
    cyc("R4", 1, 2'b01, 0, 32'hDEAD_BEEF, 1, 16'h1234, 16'h5678, 1, 1, 0);
    lit("R4", 40'h00_1234_5678, 1'b0);
    cyc("R4", 1, 2'b01, 1, 0, 0, 16'h8000, 16'h0001, 0, 0, 0);
    lit("R4", 40'hFF_8000_0001, 1'b0);
    // R2 hold
    cyc("R2", 0, 2'b00, 1, 32'h7FFF_FFFF, 1, 16'hFFFF, 16'hFFFF, 1, 1, 0);
    lit("R2", 40'hFF_8000_0001, 1'b0);
    // R6 scaled product and word pair, R5 subtract
    cyc("R6", 1, 2'b01, 1, 0, 0, 16'h0000, 16'h0100, 0, 0, 0);
    cyc("R6", 1, 2'b10, 0, 32'h8000_0010, 1, 16'h0, 16'h0, 0, 0, 0);
    lit("R6", 40'h00_0000_0120, 1'b0);
    cyc("R6", 1, 2'b10, 1, 32'h1, 0, 16'h0001, 16'h0000, 0, 0, 0);
    lit("R6", 40'h00_0001_0120, 1'b0);
    cyc("R5", 1, 2'b11, 0, 32'h0001_0121, 0, 0, 0, 0, 0, 0);
    lit("R5", 40'hFF_FFFF_FFFF, 1'b0);
    // R3 clear
    cyc("R3", 1, 2'b00, 0, 0, 0, 0, 0, 1, 1, 0);
    lit("R3", 40'h0, 1'b0);
    // R9 guard bits
    cyc("R9", 1, 2'b01, 0, 0, 0, 16'h7FFF, 16'hFFFF, 0, 0, 0);
    cyc("R9", 1, 2'b10, 1, 0, 0, 16'h0000, 16'h0001, 0, 0, 0);
    lit("R9", 40'h00_8000_0000, 1'b0);
    // R8 positive clamp
    cyc("R8", 1, 2'b01, 0, 0, 0, 16'h7FFF, 16'hFFFF, 0, 0, 0);
    cyc("R8", 1, 2'b10, 1, 0, 0, 16'h0000, 16'h0001, 0, 1, 0);
    lit("R8", 40'h00_7FFF_FFFF, 1'b1);
    // R11 clear flag without a command
    cyc("R11", 0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1);
    lit("R11", 40'h00_7FFF_FFFF, 1'b0);
    // R8 negative clamp through subtract
    cyc("R8", 1, 2'b01, 0, 0, 0, 16'h8000, 16'h0000, 0, 0, 0);
    cyc("R8", 1, 2'b11, 1, 0, 0, 16'h0000, 16'h0001, 0, 1, 0);
    lit("R8", 40'hFF_8000_0000, 1'b1);
    cyc("R11", 1, 2'b01, 0, 0, 0, 16'h7FFF, 16'hFFF0, 0, 0, 1);
    lit("R11", 40'h00_7FFF_FFF0, 1'b0);
    // R8 subtracting a negative overflows upward
    cyc("R8", 1, 2'b11, 1, 0, 0, 16'hFFFF, 16'hFFF0, 0, 1, 0);
    lit("R8", 40'h00_7FFF_FFFF, 1'b1);
    // R7 rounding alone, then round before clamp; R10 set beats clear
    cyc("R7", 1, 2'b01, 0, 0, 0, 16'h0000, 16'h8000, 0, 0, 1);
    cyc("R7", 1, 2'b10, 0, 32'h0, 0, 0, 0, 1, 0, 0);
    lit("R7", 40'h00_0001_0000, 1'b0);
    cyc("R7", 1, 2'b01, 0, 0, 0, 16'h7FFF, 16'h8000, 0, 0, 0);
    cyc("R7", 1, 2'b10, 0, 32'h0, 0, 0, 0, 1, 1, 1);
    lit("R10", 40'h00_7FFF_FFFF, 1'b1);
    // R10 40-bit wrap without clamping
    cyc("R10", 1, 2'b01, 0, 0, 0, 16'h7FFF, 16'hFFFF, 0, 0, 1);
    for (int i = 0; i < 255; i++)
      cyc("R9", 1, 2'b10, 0, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0);
    lit("R9", 40'h7F_FFFF_FF00, 1'b0);
    cyc("R10", 1, 2'b10, 0, 32'h0000_0100, 0, 0, 0, 0, 0, 0);
    lit("R10", 40'h80_0000_0000, 1'b1);
    cyc("R10", 0, 2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
    lit("R10", 40'h80_0000_0000, 1'b1);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p;
      logic [15:0] h, l;
      int k;
      k = $urandom_range(0, 3);
      p = (k == 0) ? 32'h7FFF_FFFF : (k == 1) ? 32'h8000_0000 :
          (k == 2) ? ($urandom() & 32'h0000_FFFF) : $urandom();
      h = ($urandom_range(0, 3) == 0) ? 16'h7FFF : 16'($urandom());
      l = 16'($urandom());
      cyc("R5", $urandom_range(0, 9) != 0, 2'($urandom()), 1'($urandom()), p,
          1'($urandom()), h, l, $urandom_range(0, 2) == 0,
          1'($urandom()), $urandom_range(0, 9) == 0);
      if (i == 2000) do_reset();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule